// File: doc/BRIEF.md
# Five-Level Carrier-Comparison PWM Gate Decoder

This block turns one signed modulating sample per clock into the switch commands for one phase of a five-level switched-capacitor inverter. A single triangular carrier counter runs between zero and a programmable peak. The sample is compared against four stacked copies of that carrier, two above zero and two below, all in phase. The number of copies the sample exceeds, minus two, is the output level, from -2 to +2.

The level is then decoded into three complementary switch pairs. The first pair sets the boost capacitor: series with the source for magnitude 2, parallel (charging) for magnitude 1 or 0. The other two pairs are the two H-bridge legs, giving output polarity. The zero level uses only one upper or one lower switch, and that choice flips at every carrier bottom to share losses. Each pair passes through a dead-time stage that holds both of its switches off for a fixed number of clocks whenever its commanded state changes.

The carrier is a two-state machine: CAR_RISE counts up until the count reaches the peak, then moves to CAR_FALL; CAR_FALL counts down to zero and then moves back to CAR_RISE, toggling the zero-state selector on that bottom turn; a zero peak forces CAR_RISE with the count at zero. Each dead-time stage is a two-state machine: DT_PASS drives the applied command, and moves to DT_GAP on a command change; DT_GAP drives both switches off, restarts its count on a further change, and returns to DT_PASS after the count runs out.

Top module: `fivelvl_pwm_decoder`

## Requirements
- R1: After reset the carrier value is 0 and rising; it steps by one per clock up to the peak `period_i`, then down to 0, then up again (period 2*`period_i` clocks); with `period_i` = 0 it stays at 0.
- R2: `level_o` (3-bit two's complement) equals, one clock after the sample, the count of thresholds c+P, c, c-P, c-2P that the sample strictly exceeds, minus 2, where c is the carrier value and P the peak in that cycle.
- R3: A sample above 2P gives level +2 whenever the carrier is at or below P; a sample at or below -2P gives level -2.
- R4: The capacitor pair drives `cap_series_o`=1, `cap_parallel_o`=0 for level ±2 and `cap_series_o`=0, `cap_parallel_o`=1 for levels -1, 0, +1; both are never high together.
- R5: Positive levels command `leg_a_hi_o` and `leg_b_lo_o`; negative levels command `leg_a_lo_o` and `leg_b_hi_o`; the other two bridge switches are off.
- R6: Level 0 commands only `leg_a_hi_o` while the zero selector is 0 and only `leg_a_lo_o` while it is 1; the selector is 0 after reset and toggles on each clock where the carrier turns at its bottom.
- R7: Each pair's commanded state is formed from `level_o` of the previous cycle; an unchanged command appears on the outputs one clock later; a change makes both switches of that pair low for DEAD clocks before the new state appears, and a further change during that gap restarts it.
- R8: While `rst` is high, `level_o` is 0 and all six gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_i | input | CW | Carrier peak value P |
| sample_i | input | CW+2 | Signed modulating sample |
| level_o | output | 3 | Signed output level, -2 to +2 |
| cap_series_o | output | 1 | Capacitor in series with the source |
| cap_parallel_o | output | 1 | Capacitor in parallel with the source |
| leg_a_hi_o | output | 1 | Leg A upper switch |
| leg_a_lo_o | output | 1 | Leg A lower switch |
| leg_b_hi_o | output | 1 | Leg B upper switch |
| leg_b_lo_o | output | 1 | Leg B lower switch |

## Verification
Samples held near zero with a small peak make the level swing between 0 and -1 over each carrier, which exposes the zero-state alternation and the bottom turn of the carrier. Samples inside one band (such as +5 or -5 with peak 4) move the level between 1 and 2, separating the capacitor series/parallel decode from bridge polarity, while samples beyond ±2P pin the level and show saturation. Peaks of 0, 1, 255 and a peak lowered mid-count check the counter's edge behaviour, and a step from +2 to -2 shows the leg dead-time gap at its exact length.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;

    // carrier counter direction
    typedef enum logic {
        CAR_RISE,
        CAR_FALL
    } car_state_e;

    // dead-time stage state
    typedef enum logic {
        DT_PASS,
        DT_GAP
    } dt_state_e;

    // one complementary switch pair
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_t;

    localparam int unsigned NUM_BANDS = 4;
    localparam int unsigned NUM_PAIRS = 3;

endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier
    import pwm5_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic          zsel_o
);

    car_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          zsel_q, zsel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CAR_RISE;
            cnt_q  <= '0;
            zsel_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            zsel_q <= zsel_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        zsel_d = zsel_q;
        if (period_i == '0) begin
            st_d  = CAR_RISE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                CAR_RISE: begin
                    if (cnt_q < period_i) begin
                        cnt_d = cnt_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                        st_d  = CAR_FALL;
                    end
                end
                CAR_FALL: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - 1'b1;
                    end else begin
                        cnt_d  = cnt_q + 1'b1;
                        st_d   = CAR_RISE;
                        zsel_d = ~zsel_q;
                    end
                end
                default: st_d = CAR_RISE;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign zsel_o = zsel_q;

    // R1: rising count advances by one
    a_r1_rise_step: assert property (@(posedge clk) disable iff (rst)
        (st_q == CAR_RISE && period_i != '0 && cnt_q < period_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R1: zero peak parks the carrier
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (period_i == '0) |=> (cnt_q == '0));

    // R6: selector flips at the bottom turn
    a_r6_zero_flip: assert property (@(posedge clk) disable iff (rst)
        (st_q == CAR_FALL && cnt_q == '0 && period_i != '0) |=> (zsel_q != $past(zsel_q)));

endmodule

// File: rtl/pwm5_level.sv
module pwm5_level
    import pwm5_pkg::*;
#(
    parameter int unsigned CW = 8,
    parameter int unsigned RW = CW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [RW-1:0] sample_i,
    input  logic        [CW-1:0] cnt_i,
    input  logic        [CW-1:0] period_i,
    output logic signed [2:0]    level_o
);

    localparam int unsigned EW = RW + 2;

    logic signed [EW-1:0] ref_ext, per_ext, per2, car_ext;
    logic [NUM_BANDS-1:0] hits;
    logic [2:0]           sum;
    logic signed [2:0]    level_q;

    assign ref_ext = EW'(sample_i);
    assign per_ext = EW'(period_i);
    assign car_ext = EW'(cnt_i);
    assign per2    = per_ext <<< 1;

    // shift the sample into each band, compare with the shared carrier
    for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
        logic signed [EW-1:0] shifted;
        if (k == 0) begin : g_b0
            assign shifted = ref_ext + per2;
        end else if (k == 1) begin : g_b1
            assign shifted = ref_ext + per_ext;
        end else if (k == 2) begin : g_b2
            assign shifted = ref_ext;
        end else begin : g_b3
            assign shifted = ref_ext - per_ext;
        end
        assign hits[k] = (shifted > car_ext);
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NUM_BANDS; k++) begin
            sum = sum + {2'b00, hits[k]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= signed'(sum - 3'd2);
    end

    assign level_o = level_q;

    // R2: level stays inside the five codes
    a_r2_level_range: assert property (@(posedge clk) disable iff (rst)
        (level_q >= -3'sd2) && (level_q <= 3'sd2));

    // R3: saturation above the top band
    a_r3_top_sat: assert property (@(posedge clk) disable iff (rst)
        (ref_ext > per2 && car_ext <= per_ext) |=> (level_q == 3'sd2));

    // R3: saturation below the bottom band
    a_r3_bottom_sat: assert property (@(posedge clk) disable iff (rst)
        (ref_ext <= -per2) |=> (level_q == -3'sd2));

endmodule

// File: rtl/pwm5_deadtime.sv
module pwm5_deadtime
    import pwm5_pkg::*;
#(
    parameter int unsigned DEAD = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pair_t cmd_i,
    output pair_t drv_o
);

    localparam int unsigned DW = (DEAD < 2) ? 1 : $clog2(DEAD + 1);

    dt_state_e     st_q, st_d;
    pair_t         app_q, app_d;
    pair_t         out_q, out_d;
    logic [DW-1:0] gap_q, gap_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DT_PASS;
            app_q <= '0;
            out_q <= '0;
            gap_q <= '0;
        end else begin
            st_q  <= st_d;
            app_q <= app_d;
            out_q <= out_d;
            gap_q <= gap_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        app_d = app_q;
        out_d = out_q;
        gap_d = gap_q;
        unique case (st_q)
            DT_PASS: begin
                if (cmd_i != app_q) begin
                    app_d = cmd_i;
                    if (DEAD == 0) begin
                        out_d = cmd_i;
                    end else begin
                        st_d  = DT_GAP;
                        gap_d = DW'(DEAD);
                        out_d = '0;
                    end
                end else begin
                    out_d = app_q;
                end
            end
            DT_GAP: begin
                if (cmd_i != app_q) begin
                    app_d = cmd_i;
                    gap_d = DW'(DEAD);
                end else if (gap_q == DW'(1)) begin
                    st_d  = DT_PASS;
                    out_d = app_q;
                end else begin
                    gap_d = gap_q - 1'b1;
                end
            end
            default: st_d = DT_PASS;
        endcase
    end

    assign drv_o = out_q;

    // R7: never both switches of a pair on
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(out_q.hi && out_q.lo));

    // R7: upper switch turns on only after the lower one was off
    a_r7_break_hi: assert property (@(posedge clk) disable iff (rst)
        (DEAD > 0 && $rose(out_q.hi)) |-> !$past(out_q.lo));

    // R7: lower switch turns on only after the upper one was off
    a_r7_break_lo: assert property (@(posedge clk) disable iff (rst)
        (DEAD > 0 && $rose(out_q.lo)) |-> !$past(out_q.hi));

    // R7: gap state drives the pair idle
    a_r7_gap_idle: assert property (@(posedge clk) disable iff (rst)
        (st_q == DT_GAP) |-> (out_q == '0));

endmodule

// File: rtl/fivelvl_pwm_decoder.sv
module fivelvl_pwm_decoder
    import pwm5_pkg::*;
#(
    parameter int unsigned CW   = 8,
    parameter int unsigned DEAD = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CW-1:0]        period_i,
    input  logic signed [CW+1:0] sample_i,
    output logic signed [2:0]    level_o,
    output logic                 cap_series_o,
    output logic                 cap_parallel_o,
    output logic                 leg_a_hi_o,
    output logic                 leg_a_lo_o,
    output logic                 leg_b_hi_o,
    output logic                 leg_b_lo_o
);

    localparam int unsigned RW = CW + 2;

    logic [CW-1:0]     cnt;
    logic              zsel;
    logic signed [2:0] lvl;
    pair_t             cmd [NUM_PAIRS];
    pair_t             drv [NUM_PAIRS];

    pwm5_carrier #(.CW(CW)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .cnt_o    (cnt),
        .zsel_o   (zsel)
    );

    pwm5_level #(.CW(CW), .RW(RW)) u_level (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_i),
        .cnt_i    (cnt),
        .period_i (period_i),
        .level_o  (lvl)
    );

    // level to pair commands: 0 capacitor, 1 leg A, 2 leg B
    always_comb begin
        cmd[0] = '{hi: 1'b0, lo: 1'b1};
        cmd[1] = '0;
        cmd[2] = '0;
        unique case (lvl)
            3'sd2: begin
                cmd[0] = '{hi: 1'b1, lo: 1'b0};
                cmd[1] = '{hi: 1'b1, lo: 1'b0};
                cmd[2] = '{hi: 1'b0, lo: 1'b1};
            end
            3'sd1: begin
                cmd[1] = '{hi: 1'b1, lo: 1'b0};
                cmd[2] = '{hi: 1'b0, lo: 1'b1};
            end
            3'sd0: begin
                cmd[1] = zsel ? '{hi: 1'b0, lo: 1'b1} : '{hi: 1'b1, lo: 1'b0};
            end
            -3'sd1: begin
                cmd[1] = '{hi: 1'b0, lo: 1'b1};
                cmd[2] = '{hi: 1'b1, lo: 1'b0};
            end
            -3'sd2: begin
                cmd[0] = '{hi: 1'b1, lo: 1'b0};
                cmd[1] = '{hi: 1'b0, lo: 1'b1};
                cmd[2] = '{hi: 1'b1, lo: 1'b0};
            end
            default: begin
                cmd[1] = '0;
                cmd[2] = '0;
            end
        endcase
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pwm5_deadtime #(.DEAD(DEAD)) u_dt (
            .clk   (clk),
            .rst   (rst),
            .cmd_i (cmd[p]),
            .drv_o (drv[p])
        );
    end

    assign level_o        = lvl;
    assign cap_series_o   = drv[0].hi;
    assign cap_parallel_o = drv[0].lo;
    assign leg_a_hi_o     = drv[1].hi;
    assign leg_a_lo_o     = drv[1].lo;
    assign leg_b_hi_o     = drv[2].hi;
    assign leg_b_lo_o     = drv[2].lo;

    // R8: reset clears level and gates on the following cycle
    a_r8_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (lvl == 3'sd0 && !cap_series_o && !cap_parallel_o &&
                        !leg_a_hi_o && !leg_a_lo_o && !leg_b_hi_o && !leg_b_lo_o));

endmodule

// File: tb/test_fivelvl_pwm_decoder.sv
`timescale 1ns/1ps
module test_fivelvl_pwm_decoder;

    localparam int CW   = 8;
    localparam int DEAD = 2;
    localparam int NV   = 14;

    // each entry: {peak[25:18], sample[17:8], cycles[7:0]}
    localparam logic [25:0] VEC [NV] = '{
        {8'd4,   10'sd0,    8'd24},
        {8'd4,   10'sd5,    8'd16},
        {8'd4,   -10'sd5,   8'd16},
        {8'd4,   10'sd9,    8'd12},
        {8'd4,   -10'sd8,   8'd12},
        {8'd1,   10'sd1,    8'd10},
        {8'd0,   10'sd3,    8'd6},
        {8'd10,  -10'sd3,   8'd40},
        {8'd10,  10'sd14,   8'd40},
        {8'd255, 10'sd300,  8'd20},
        {8'd255, -10'sd511, 8'd10},
        {8'd6,   10'sd2,    8'd30},
        {8'd3,   -10'sd1,   8'd30},
        {8'd2,   10'sd0,    8'd20}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CW-1:0]     period = 8'd4;
    logic signed [CW+1:0] sample = '0;
    logic signed [2:0] level;
    logic sa, sb, ahi, alo, bhi, blo;

    always #2.5 clk = ~clk;

    fivelvl_pwm_decoder #(.CW(CW), .DEAD(DEAD)) i_fivelvl_pwm_decoder (
        .clk            (clk),
        .rst            (rst),
        .period_i       (period),
        .sample_i       (sample),
        .level_o        (level),
        .cap_series_o   (sa),
        .cap_parallel_o (sb),
        .leg_a_hi_o     (ahi),
        .leg_a_lo_o     (alo),
        .leg_b_hi_o     (bhi),
        .leg_b_lo_o     (blo)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int seen_z1 = 0;
    int seen_z2 = 0;

    // reference model state
    int         m_cnt;
    bit         m_fall;
    bit         m_zsel;
    int         m_level;
    logic [1:0] m_app [3];
    logic [1:0] m_out [3];
    int         m_gap [3];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int f_level(input int r, input int c, input int p);
        int n = 0;
        if (r > c + p)     n++;
        if (r > c)         n++;
        if (r > c - p)     n++;
        if (r > c - 2 * p) n++;
        return n - 2;
    endfunction

    // {series, parallel, a_hi, a_lo, b_hi, b_lo}
    function automatic logic [5:0] f_cmd(input int lvl, input bit z);
        case (lvl)
            2:       return 6'b10_10_01;
            1:       return 6'b01_10_01;
            0:       return z ? 6'b01_01_00 : 6'b01_10_00;
            -1:      return 6'b01_01_10;
            default: return 6'b10_01_10;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_fall = 0; m_zsel = 0; m_level = 0;
        for (int i = 0; i < 3; i++) begin
            m_app[i] = '0; m_out[i] = '0; m_gap[i] = 0;
        end
    endtask

    task automatic pair_step(input int i, input logic [1:0] t);
        if (m_gap[i] == 0) begin
            if (t != m_app[i]) begin
                m_app[i] = t;
                if (DEAD == 0) m_out[i] = t;
                else begin m_gap[i] = DEAD; m_out[i] = '0; end
            end else m_out[i] = m_app[i];
        end else begin
            if (t != m_app[i]) begin
                m_app[i] = t; m_gap[i] = DEAD;
            end else if (m_gap[i] == 1) begin
                m_gap[i] = 0; m_out[i] = m_app[i];
            end else m_gap[i]--;
        end
    endtask

    task automatic model_step();
        logic [5:0] t;
        int p, r, nl;
        t  = f_cmd(m_level, m_zsel);
        p  = int'(period);
        r  = int'(sample);
        for (int i = 0; i < 3; i++) pair_step(i, t[5-2*i -: 2]);
        nl = f_level(r, m_cnt, p);
        if (p == 0) begin
            m_cnt = 0; m_fall = 0;
        end else if (!m_fall) begin
            if (m_cnt < p) m_cnt++;
            else begin m_cnt--; m_fall = 1; end
        end else begin
            if (m_cnt != 0) m_cnt--;
            else begin m_cnt++; m_fall = 0; m_zsel = !m_zsel; end
        end
        m_level = nl;
    endtask

    task automatic compare();
        int p, r;
        string tag;
        p = int'(period);
        r = int'(sample);
        tag = (m_level == 2 || m_level == -2) ? "R3" : "R1/R2";
        check(level == 3'(m_level), tag, "level", int'(level), m_level);
        check({sa, sb} == m_out[0], "R4/R7", "capacitor pair", int'({sa, sb}), int'(m_out[0]));
        check({ahi, alo} == m_out[1], "R5/R6/R7", "leg A pair", int'({ahi, alo}), int'(m_out[1]));
        check({bhi, blo} == m_out[2], "R5/R7", "leg B pair", int'({bhi, blo}), int'(m_out[2]));
        if ({sa, sb, ahi, alo, bhi, blo} == 6'b01_10_00) seen_z1++;
        if ({sa, sb, ahi, alo, bhi, blo} == 6'b01_01_00) seen_z2++;
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic reset_phase();
        rst = 1'b1;
        model_reset();
        repeat (3) begin
            @(negedge clk);
            // R8: reset state
            check(level == 3'sd0, "R8", "level in reset", int'(level), 0);
            check({sa, sb, ahi, alo, bhi, blo} == 6'b0, "R8", "gates in reset",
                  int'({sa, sb, ahi, alo, bhi, blo}), 0);
        end
        rst = 1'b0;
    endtask

    initial begin
        int idle;
        reset_phase();
        for (int i = 0; i < NV; i++) begin
            period = VEC[i][25:18];
            sample = VEC[i][17:8];
            repeat (int'(VEC[i][7:0])) tick();
        end

        // mid-run reset, then zero region again
        reset_phase();
        period = 8'd4;
        sample = '0;
        repeat (30) tick();

        // R6: both zero states must have been driven
        check(seen_z1 > 0, "R6", "zero via leg A upper seen", seen_z1, 1);
        check(seen_z2 > 0, "R6", "zero via leg A lower seen", seen_z2, 1);

        // R7: gap length on a polarity reversal of leg A
        sample = 10'sd9;
        repeat (12) tick();
        sample = -10'sd8;
        idle = 0;
        repeat (10) begin
            tick();
            if (!ahi && !alo) idle++;
        end
        check(idle == DEAD, "R7", "leg A idle cycles on reversal", idle, DEAD);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule